// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that forces a system reset when software stops servicing it. An 8-bit down counter is decremented once per prescaler period. The prescaler period is a base of 32 selected clock ticks, doubled once for each step of a 3-bit select field, so there are eight timeout lengths. The counter counts ticks from one of two enable inputs. One comes from a dedicated slow oscillator, already synchronised to the block clock. The other comes from the peripheral clock.

Software services the watchdog with a two-write key sequence across two separate addresses. A valid sequence restarts the prescaler and reloads the counter from a byte-wide load register. If the counter underflows while the watchdog runs, the block raises a one-cycle reset request and sets a sticky timeout flag. That flag survives the system reset that follows, so software can tell that the watchdog caused the reset. Only power-on reset clears it.

Register access is by byte-wide writes and reads. Address 0 is control, address 1 is load, addresses 2 and 3 are the two feed keys. A read of address 2 or 3 returns the live counter value.

Top module: `wdog_prescaled`

## Requirements
- R1: After power-on reset, control reads 0xE5, load reads 0xFF and the counter reads 0xFF.
- R2: Control bits are [7:5] prescale select, [4:3] unused, [2] run, [1] timeout flag, [0] clock select. Unused bits always read 0 and writes never change the timeout flag.
- R3: Measured from a valid feed with load value L and select P, the reset request rises after exactly (L+1)*32*2^P selected ticks, and it is high for one cycle only.
- R4: On underflow the counter reloads from the load register and the prescaler restarts, so an unserviced watchdog repeats the same timeout period.
- R5: A feed is a write of 0xA5 to address 2 followed, as the very next write, by 0x5A to address 3. It reloads the counter from load. Repeated 0xA5 writes to address 2 keep the sequence armed. A write to load alone does not change the counter.
- R6: A wrong key value, the reverse order, a lone second key, or any other write between the two keys causes no reload.
- R7: With run at 0 the counter holds and no reset request is raised, but a feed still reloads the counter.
- R8: Clock select 1 counts the oscillator tick input. Clock select 0 counts the peripheral tick input, and the unselected input is ignored.
- R9: Expiry sets the timeout flag. A system reset restores every other field (control reads 0xE7) but keeps the flag. Power-on reset clears it.
- R10: A write to control restarts the prescaler with the newly written select and does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset, asynchronous, active low |
| sysRst | input | 1 | Synchronous system reset from any other cause |
| oscTick | input | 1 | One-cycle tick from the dedicated watchdog oscillator |
| periphTick | input | 1 | One-cycle tick from the peripheral clock |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 control, 1 load, 2 first key, 3 second key) |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address (2 or 3 returns the counter) |
| rdData | output | 8 | Read data, combinational |
| rstReq | output | 1 | One-cycle reset request on expiry |

## Verification
The bench sweeps all eight prescale selects against several load values and counts the cycles to the reset request. A design that is off by one in the counter or in the prescaler would expire one prescaler period, or one tick, early or late. It tries every broken key pattern, including an unrelated write between the keys. A design that arms on the data value alone, rather than on write order, would reload when it must not. It checks the second period without a feed, which catches a prescaler left mid-count at underflow. It also checks that the flag survives the system reset, which catches a flag wired to the ordinary reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned PRE_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOAD  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_KEY_A = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_KEY_B = 2'd3;

  localparam logic [DATA_W-1:0] KEY_A = 8'hA5;
  localparam logic [DATA_W-1:0] KEY_B = 8'h5A;

  typedef struct packed {
    logic reload;
    logic decrement;
  } cntStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRst,
  input  logic              oscTick,
  input  logic              periphTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              flagIn,
  input  logic [DATA_W-1:0] countIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] loadOut,
  output cntStrobe_t        strobe
);
  localparam int unsigned PW = BASE_LOG2 + (1 << PRE_W) - 1;

  function automatic logic [PW-1:0] spanOf(input logic [PRE_W-1:0] sel);
    return (PW'(1) << (BASE_LOG2 + 32'(sel))) - PW'(1);
  endfunction

  logic [PRE_W-1:0]  preQ;
  logic              runQ;
  logic              clkSelQ;
  logic [DATA_W-1:0] loadQ;
  logic              armedQ;
  logic [PW-1:0]     prescQ;

  logic tickSel, ctrlWr, loadWr, keyAHit, feedOk, prescZero;

  always_comb begin
    tickSel   = clkSelQ ? oscTick : periphTick;
    ctrlWr    = wrEn && (wrAddr == ADDR_CTRL);
    loadWr    = wrEn && (wrAddr == ADDR_LOAD);
    keyAHit   = (wrAddr == ADDR_KEY_A) && (wrData == KEY_A);
    feedOk    = wrEn && armedQ && (wrAddr == ADDR_KEY_B) && (wrData == KEY_B);
    prescZero = (prescQ == '0);
    strobe.reload    = feedOk;
    strobe.decrement = runQ && tickSel && prescZero && !feedOk && !ctrlWr;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      preQ    <= '1;
      runQ    <= 1'b1;
      clkSelQ <= 1'b1;
      loadQ   <= '1;
      armedQ  <= 1'b0;
      prescQ  <= spanOf('1);
    end else if (sysRst) begin
      preQ    <= '1;
      runQ    <= 1'b1;
      clkSelQ <= 1'b1;
      loadQ   <= '1;
      armedQ  <= 1'b0;
      prescQ  <= spanOf('1);
    end else begin
      if (ctrlWr) begin
        preQ    <= wrData[7:5];
        runQ    <= wrData[2];
        clkSelQ <= wrData[0];
      end
      if (loadWr) loadQ <= wrData;
      if (wrEn) armedQ <= keyAHit;
      if (feedOk)
        prescQ <= spanOf(preQ);
      else if (ctrlWr)
        prescQ <= spanOf(wrData[7:5]);
      else if (runQ && tickSel)
        prescQ <= prescZero ? spanOf(preQ) : prescQ - PW'(1);
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_CTRL: rdData = {preQ, 2'b00, runQ, flagIn, clkSelQ};
      ADDR_LOAD: rdData = loadQ;
      default:   rdData = countIn;
    endcase
  end

  assign loadOut = loadQ;

  // R3: prescaler never exceeds the span of the current select
  p_presc_bound_r3: assert property (@(posedge clk) disable iff (!porN)
    prescQ <= spanOf(preQ));

  // R7: a stopped watchdog never asks for a decrement
  p_stop_no_dec_r7: assert property (@(posedge clk) disable iff (!porN)
    !runQ |-> !strobe.decrement);

  // R5: a completed feed consumes the armed key
  p_feed_disarms_r5: assert property (@(posedge clk) disable iff (!porN)
    strobe.reload |=> !armedQ);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRst,
  input  cntStrobe_t        strobe,
  input  logic [DATA_W-1:0] loadIn,
  output logic [DATA_W-1:0] countOut,
  output logic              flagOut,
  output logic              rstReq
);
  logic [DATA_W-1:0] countQ;
  logic              flagQ;
  logic              reqQ;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      countQ <= '1;
      flagQ  <= 1'b0;
      reqQ   <= 1'b0;
    end else if (sysRst) begin
      countQ <= '1;
      reqQ   <= 1'b0;
    end else begin
      reqQ <= 1'b0;
      if (strobe.reload) begin
        countQ <= loadIn;
      end else if (strobe.decrement) begin
        if (countQ == '0) begin
          countQ <= loadIn;
          reqQ   <= 1'b1;
          flagQ  <= 1'b1;
        end else begin
          countQ <= countQ - 1'b1;
        end
      end
    end
  end

  assign countOut = countQ;
  assign flagOut  = flagQ;
  assign rstReq   = reqQ;

  // R5: a feed loads the load register value
  p_reload_value_r5: assert property (@(posedge clk) disable iff (!porN)
    strobe.reload && !sysRst |=> countQ == $past(loadIn));

  // R3: reset request lasts one cycle
  p_req_single_r3: assert property (@(posedge clk) disable iff (!porN)
    reqQ |=> !reqQ);

  // R4: expiry leaves the counter at the load value
  p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!porN)
    reqQ |-> countQ == $past(loadIn));

  // R9: flag accompanies every request and never falls without power-on reset
  p_req_flag_r9: assert property (@(posedge clk) disable iff (!porN)
    reqQ |-> flagQ);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!porN)
    flagQ |=> flagQ);
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              sysRst,
  input  logic              oscTick,
  input  logic              periphTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq
);
  cntStrobe_t        strobe;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] countVal;
  logic              flagVal;

  wdog_ctrl #(.BASE_LOG2(BASE_LOG2)) u_ctrl (
    .clk(clk), .porN(porN), .sysRst(sysRst),
    .oscTick(oscTick), .periphTick(periphTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .flagIn(flagVal), .countIn(countVal),
    .rdData(rdData), .loadOut(loadVal), .strobe(strobe)
  );

  wdog_count u_count (
    .clk(clk), .porN(porN), .sysRst(sysRst),
    .strobe(strobe), .loadIn(loadVal),
    .countOut(countVal), .flagOut(flagVal), .rstReq(rstReq)
  );
endmodule

// File: tb/sim_wdog_prescaled.sv
module sim_wdog_prescaled;
  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic       sysRst = 1'b0;
  logic       oscTick = 1'b0;
  logic       periphTick = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [1:0] rdAddr = 2'd0;
  logic [7:0] rdData;
  logic       rstReq;

  int nChk = 0;
  int nBad = 0;
  int reqSeen = 0;
  logic done = 1'b0;

  wdog_prescaled u0 (.*);

  always #10 clk = ~clk;

  always @(negedge clk) if (rstReq) reqSeen++;

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rdAddr = a;
    #1;
    v = int'(rdData);
  endtask

  task automatic feed();
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
  endtask

  task automatic waitReq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rstReq && n < 40000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int v, n, seen0;
    repeat (3) @(negedge clk);
    porN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 8'hE5);
    rd(2'd1, v); check("R1 load", v, 8'hFF);
    rd(2'd2, v); check("R1 count", v, 8'hFF);

    // R2 unused bits and flag not writable
    wr(2'd0, 8'h1A); rd(2'd0, v); check("R2 masked write", v, 8'h00);
    wr(2'd0, 8'hFF); rd(2'd0, v); check("R2 full write", v, 8'hE5);

    // R5 and R6 with ticks off
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h37); rd(2'd2, v); check("R5 load write alone", v, 8'hFF);
    feed(); rd(2'd2, v); check("R5 valid feed", v, 8'h37);
    wr(2'd1, 8'h10);
    wr(2'd2, 8'hA4); wr(2'd3, 8'h5A); rd(2'd2, v); check("R6 wrong first key", v, 8'h37);
    wr(2'd2, 8'hA5); wr(2'd1, 8'h10); wr(2'd3, 8'h5A); rd(2'd2, v); check("R6 interposed write", v, 8'h37);
    wr(2'd3, 8'h5A); rd(2'd2, v); check("R6 lone second key", v, 8'h37);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5B); rd(2'd2, v); check("R6 wrong second key", v, 8'h37);
    wr(2'd3, 8'h5A); wr(2'd2, 8'hA5); wr(2'd0, 8'h04); rd(2'd2, v); check("R6 reverse order", v, 8'h37);
    wr(2'd2, 8'hA5); wr(2'd2, 8'hA5); wr(2'd3, 8'h5A); rd(2'd2, v); check("R5 repeated first key", v, 8'h10);

    // R7 stopped watchdog
    wr(2'd0, 8'h00);
    seen0 = reqSeen;
    periphTick = 1'b1;
    repeat (200) @(negedge clk);
    rd(2'd2, v); check("R7 count held", v, 8'h10);
    check("R7 no request", reqSeen - seen0, 0);
    wr(2'd1, 8'h22); feed(); rd(2'd2, v); check("R7 feed while stopped", v, 8'h22);
    periphTick = 1'b0;

    // R3 sweep of selects and loads
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 3; k++) begin
        int ld;
        ld = (k == 2) ? 3 : k;
        wr(2'd0, {p[2:0], 5'b00100});
        wr(2'd1, ld[7:0]);
        feed();
        periphTick = 1'b1;
        waitReq(n);
        periphTick = 1'b0;
        check($sformatf("R3 timeout sel %0d load %0d", p, ld), n, (ld + 1) * (32 << p));
        if (p == 0 && k == 0) begin
          rd(2'd0, v); check("R9 flag set", (v >> 1) & 1, 1);
        end
        @(negedge clk);
        check("R3 one-cycle request", int'(rstReq), 0);
        rd(2'd2, v); check("R4 reload after expiry", v, ld);
      end
    end

    // R4 repeated period without feed
    wr(2'd0, 8'h04); wr(2'd1, 8'h02); feed();
    periphTick = 1'b1;
    waitReq(n); check("R4 first period", n, 96);
    waitReq(n); check("R4 second period", n, 96);
    periphTick = 1'b0;

    // R8 clock select
    wr(2'd0, 8'h05); wr(2'd1, 8'h01); feed();
    seen0 = reqSeen;
    periphTick = 1'b1;
    repeat (100) @(negedge clk);
    periphTick = 1'b0;
    rd(2'd2, v); check("R8 peripheral tick ignored", v, 1);
    check("R8 no request", reqSeen - seen0, 0);
    feed();
    oscTick = 1'b1;
    waitReq(n); check("R8 oscillator timeout", n, 64);
    oscTick = 1'b0;

    // R10 control write restarts prescaler
    wr(2'd0, 8'h04); wr(2'd1, 8'h02); feed();
    periphTick = 1'b1;
    repeat (20) @(negedge clk);
    wr(2'd0, 8'h04);
    rd(2'd2, v); check("R10 count unchanged", v, 2);
    waitReq(n); check("R10 restarted timeout", n, 96);
    periphTick = 1'b0;

    // R9 flag survives system reset, cleared by power-on
    @(negedge clk); sysRst = 1'b1;
    repeat (2) @(negedge clk); sysRst = 1'b0;
    rd(2'd0, v); check("R9 ctrl after system reset", v, 8'hE7);
    rd(2'd1, v); check("R9 load after system reset", v, 8'hFF);
    rd(2'd2, v); check("R9 count after system reset", v, 8'hFF);
    porN = 1'b0;
    @(negedge clk); porN = 1'b1;
    @(negedge clk);
    rd(2'd0, v); check("R9 ctrl after power-on", v, 8'hE5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule